// File: doc/BRIEF.md
# Windowed Watchdog Timer with Event Routing

This block is a watchdog that runs from a slow clock. A power-of-two prescaler divides that clock and produces ticks, and each tick decrements a 12-bit down counter. Software keeps the system alive by issuing restart commands, and each restart reloads the counter with the programmed period. The watchdog checks both sides of the window. If the counter runs out, that is a timeout. If a restart arrives before a minimum interval has passed, that is also a fault.

Three events are tracked: the period timeout, the early-restart (repeat) violation, and the counter crossing a programmed level. Each event sets a sticky status bit that clears on a read strobe. Each status bit can be unmasked onto the interrupt line. The timeout and the repeat violation can also each raise a one-cycle reset request.

Configuration arrives through a plain write port. A value above its programmable limit is clamped to that limit. A write that would break the ordering between thresholds and period is dropped, and a sticky error bit is set. Out of reset the watchdog is already counting from the maximum period with reset generation enabled.

Top module: `wwdt_top`

## Requirements
- R1: After reset the count is 0xFFF, period 0xFFF, prescaler 0, both thresholds 0, all limits 0xFFF, mask 0, status 0, disable 0, period-reset enable 1, repeat-reset enable 0; irq_o and rst_req_o are low.
- R2: With prescaler value P, the count decrements once every 2^(7-P) clock cycles. The divider phase starts at zero after reset, after a restart, and while disabled.
- R3: An accepted restart loads the count with the period on the next edge and restarts the divider phase.
- R4: A tick that would bring the count to zero instead reloads the period and sets status bit 0. If the period-reset enable is set, rst_req_o is high for the following cycle.
- R5: A restart taken while (period - count) < repeat threshold sets status bit 1. If the repeat-reset enable is set, rst_req_o is high for the following cycle.
- R6: A tick that takes the count from L+1 to L, where L is the level threshold, sets status bit 2. With L = 0 this is the same tick as the period event.
- R7: irq_o is high whenever some status bit among bits 0..2 is set together with the mask bit in the same position.
- R8: Status bits are sticky. Bit 0 is period, bit 1 is repeat, bit 2 is level and bit 3 is configuration error. rd_clr_i clears all four, except that an event in the same cycle leaves its own bit set.
- R9: While the disable bit is set, the count holds, restarts are ignored, and no event or reset request occurs.
- R10: A period write that is not above both thresholds is discarded, as is a threshold write that is not below the period. Such a write sets status bit 3.
- R11: A period, repeat-threshold or level-threshold write above its limit register is clamped to that limit before the range check.
- R12: When a restart and a tick fall in the same cycle, the restart wins. No period or level event is raised for that tick.
- R13: The write addresses are as follows. Address 0 is the mode register: bit0 disable, bit1 period-reset enable, bit2 repeat-reset enable. Address 1 is the mask, with bits in the status order. Address 2 is the period, address 3 is the prescaler (bits 2:0), address 4 is the repeat threshold and address 5 is the level threshold. Addresses 6, 7 and 8 are the limits for period, repeat threshold and level threshold. Other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Restart command |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 12 | Register write data |
| rd_clr_i | input | 1 | Status read strobe, clears sticky bits |
| count_o | output | 12 | Current counter value |
| stat_o | output | 4 | Sticky status {cfg_err, level, repeat, period} |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Two collisions matter most. The first is a restart in the same cycle as a divider tick, which includes the tick that would time out the counter. The second is a status read strobe in the same cycle as a fresh event. With the fastest prescaler every cycle is a tick, so restarts at every offset inside the period hit the first collision. Periodic read strobes placed against period, level and repeat events hit the second. A behavioural model in the bench decides the expected count, status, interrupt and reset request for every cycle, and the outputs are compared cycle by cycle. Setting the level threshold to zero also makes the period and level events coincide on one tick.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int CNT_W  = 12;
  localparam int PSC_W  = 3;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE   = 4'd0,
    A_MASK   = 4'd1,
    A_PERIOD = 4'd2,
    A_PRESC  = 4'd3,
    A_RPTH   = 4'd4,
    A_LVL    = 4'd5,
    A_PLIM   = 4'd6,
    A_RLIM   = 4'd7,
    A_LLIM   = 4'd8
  } addr_e;

  typedef struct packed {
    logic rep_rst;
    logic per_rst;
    logic dis;
  } mode_t;

  typedef struct packed {
    logic lvl;
    logic rep;
    logic per;
  } evt_t;
endpackage

// File: rtl/wwdt_regs.sv
module wwdt_regs
  import wwdt_pkg::*;
#(
  parameter int CNT_W  = wwdt_pkg::CNT_W,
  parameter int PSC_W  = wwdt_pkg::PSC_W,
  parameter int ADDR_W = wwdt_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output mode_t             mode_o,
  output evt_t              mask_o,
  output logic [CNT_W-1:0]  period_o,
  output logic [PSC_W-1:0]  presc_o,
  output logic [CNT_W-1:0]  rpth_o,
  output logic [CNT_W-1:0]  lvl_o,
  output logic              err_o
);
  localparam int NLIM = 3;  // 0: period, 1: repeat, 2: level

  logic [NLIM-1:0][CNT_W-1:0] lim_q;
  logic [NLIM-1:0][CNT_W-1:0] clamp;
  mode_t             mode_q;
  evt_t              mask_q;
  logic [CNT_W-1:0]  period_q, rpth_q, lvl_q;
  logic [PSC_W-1:0]  presc_q;
  logic              ok_per, ok_rep, ok_lvl;

  for (genvar i = 0; i < NLIM; i++) begin : g_clamp
    assign clamp[i] = (wr_data_i > lim_q[i]) ? lim_q[i] : wr_data_i;
  end

  always_comb begin
    ok_per = (clamp[0] > rpth_q) && (clamp[0] > lvl_q);
    ok_rep = clamp[1] < period_q;
    ok_lvl = clamp[2] < period_q;
    err_o  = wr_en_i && (((wr_addr_i == A_PERIOD) && !ok_per) ||
                         ((wr_addr_i == A_RPTH)   && !ok_rep) ||
                         ((wr_addr_i == A_LVL)    && !ok_lvl));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '1;
    end else if (wr_en_i) begin
      for (int i = 0; i < NLIM; i++)
        if (wr_addr_i == ADDR_W'(A_PLIM) + ADDR_W'(i)) lim_q[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '{rep_rst: 1'b0, per_rst: 1'b1, dis: 1'b0};
      mask_q   <= '0;
      period_q <= '1;
      presc_q  <= '0;
      rpth_q   <= '0;
      lvl_q    <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_MODE:   mode_q  <= mode_t'(wr_data_i[2:0]);
        A_MASK:   mask_q  <= evt_t'(wr_data_i[2:0]);
        A_PRESC:  presc_q <= wr_data_i[PSC_W-1:0];
        A_PERIOD: if (ok_per) period_q <= clamp[0];
        A_RPTH:   if (ok_rep) rpth_q   <= clamp[1];
        A_LVL:    if (ok_lvl) lvl_q    <= clamp[2];
        default: ;
      endcase
    end
  end

  assign mode_o   = mode_q;
  assign mask_o   = mask_q;
  assign period_o = period_q;
  assign presc_o  = presc_q;
  assign rpth_o   = rpth_q;
  assign lvl_o    = lvl_q;
endmodule

// File: rtl/wwdt_presc.sv
module wwdt_presc #(
  parameter int PSC_W = wwdt_pkg::PSC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] presc_i,
  output logic             tick_o
);
  localparam int DIV_W = 2**PSC_W - 1;

  logic [DIV_W-1:0] pre_q;
  logic [PSC_W-1:0] sh;
  logic [DIV_W:0]   lim;

  assign sh     = PSC_W'(DIV_W) - presc_i;
  assign lim    = ({{DIV_W{1'b0}}, 1'b1} << sh) - 1'b1;
  // >= keeps a shrinking divider from wrapping through the full range
  assign tick_o = !clr_i && ({1'b0, pre_q} >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (clr_i || tick_o)   pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
  import wwdt_pkg::*;
#(
  parameter int CNT_W = wwdt_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] rpth_i,
  input  logic [CNT_W-1:0] lvl_i,
  output logic [CNT_W-1:0] cnt_o,
  output evt_t             ev_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last = cnt_q <= CNT_W'(1);

  always_comb begin
    ev_o.per = tick_i && last;
    ev_o.lvl = tick_i && ((cnt_q - 1'b1) == lvl_i);
    // elapsed = period - count; early when elapsed < threshold
    ev_o.rep = restart_i &&
               (({1'b0, cnt_q} + {1'b0, rpth_i}) > {1'b0, period_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '1;
    else if (restart_i) cnt_q <= period_i;
    else if (tick_i)    cnt_q <= last ? period_i : cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wwdt_status.sv
module wwdt_status
  import wwdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  evt_t       ev_i,
  input  logic       err_i,
  input  logic       rd_clr_i,
  input  evt_t       mask_i,
  input  mode_t      mode_i,
  output logic [3:0] stat_o,
  output logic       irq_o,
  output logic       rst_req_o
);
  logic [3:0] stat_q;
  logic       req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      req_q  <= 1'b0;
    end else begin
      stat_q <= (rd_clr_i ? 4'b0 : stat_q) | {err_i, ev_i};
      req_q  <= (ev_i.per && mode_i.per_rst) || (ev_i.rep && mode_i.rep_rst);
    end
  end

  assign stat_o    = stat_q;
  assign irq_o     = |(stat_q[2:0] & mask_i);
  assign rst_req_o = req_q;
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
#(
  parameter int CNT_W  = wwdt_pkg::CNT_W,
  parameter int PSC_W  = wwdt_pkg::PSC_W,
  parameter int ADDR_W = wwdt_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              rd_clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [3:0]        stat_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  mode_t            mode;
  evt_t             mask, ev;
  logic [CNT_W-1:0] period, rpth, lvl;
  logic [PSC_W-1:0] presc;
  logic             err, tick, restart_acc, dis;

  assign dis         = mode.dis;
  assign restart_acc = restart_i && !dis;

  wwdt_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mode_o(mode), .mask_o(mask), .period_o(period), .presc_o(presc),
    .rpth_o(rpth), .lvl_o(lvl), .err_o(err)
  );

  wwdt_presc #(.PSC_W(PSC_W)) u_presc (
    .clk_i, .rst_ni, .clr_i(restart_acc || dis), .presc_i(presc), .tick_o(tick)
  );

  wwdt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .tick_i(tick), .restart_i(restart_acc),
    .period_i(period), .rpth_i(rpth), .lvl_i(lvl), .cnt_o(count_o), .ev_o(ev)
  );

  wwdt_status u_stat (
    .clk_i, .rst_ni, .ev_i(ev), .err_i(err), .rd_clr_i, .mask_i(mask),
    .mode_i(mode), .stat_o, .irq_o, .rst_req_o
  );
endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk #(
  parameter int CNT_W = wwdt_pkg::CNT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             restart_i,
  input logic             dis,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] rpth,
  input logic [CNT_W-1:0] lvl,
  input logic             rst_req_o
);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis |=> $stable(count_o));

  a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !dis) |=> (count_o == $past(period)));

  a_r10_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpth < period) && (lvl < period));

  a_r4_no_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o != '0);

  a_r9_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !$past(dis));
endmodule

bind wwdt_top wwdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart_i), .dis(dis),
  .count_o(count_o), .period(period), .rpth(rpth), .lvl(lvl),
  .rst_req_o(rst_req_o)
);

// File: tb/sim_wwdt_top.sv
module sim_wwdt_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0, we = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [11:0] data = '0;
  logic [11:0] count;
  logic [3:0]  stat;
  logic        irq, rreq;

  int    n_chk = 0, n_fail = 0, cyc_n = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt, m_pre, m_period, m_presc, m_rpth, m_lvl, m_mask, m_stat;
  int m_lim[3];
  bit m_dis, m_prst, m_rrst, m_rreq;

  always #4 clk = ~clk;

  wwdt_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .wr_en_i(we),
    .wr_addr_i(addr), .wr_data_i(data), .rd_clr_i(rd), .count_o(count),
    .stat_o(stat), .irq_o(irq), .rst_req_o(rreq)
  );

  task automatic check(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", r, act, exp, cyc_n);
    end
  endtask

  function automatic int cl(int v, int l);
    return (v > l) ? l : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 4095; m_pre = 0; m_period = 4095; m_presc = 0; m_rpth = 0;
      m_lvl = 0; m_mask = 0; m_stat = 0; m_lim = '{4095, 4095, 4095};
      m_dis = 0; m_prst = 1; m_rrst = 0; m_rreq = 0;
    end else begin
      automatic int lim = (1 << (7 - m_presc)) - 1;
      automatic bit ra = restart && !m_dis;
      automatic bit tk = !m_dis && !ra && (m_pre >= lim);
      automatic int ev = 0;
      automatic int v;
      automatic int d = int'(data);
      if (ra) begin
        if ((m_period - m_cnt) < m_rpth) ev |= 2;
        m_cnt = m_period; m_pre = 0;
      end else if (m_dis) m_pre = 0;
      else if (tk) begin
        m_pre = 0;
        if (m_cnt - 1 == m_lvl) ev |= 4;
        if (m_cnt <= 1) begin ev |= 1; m_cnt = m_period; end
        else m_cnt--;
      end else m_pre++;
      m_rreq = ((ev & 1) != 0 && m_prst) || ((ev & 2) != 0 && m_rrst);
      if (we) begin
        case (int'(addr))
          0: begin m_dis = d[0]; m_prst = d[1]; m_rrst = d[2]; end
          1: m_mask = d & 7;
          2: begin v = cl(d, m_lim[0]);
               if (v > m_rpth && v > m_lvl) m_period = v; else ev |= 8; end
          3: m_presc = d & 7;
          4: begin v = cl(d, m_lim[1]);
               if (v < m_period) m_rpth = v; else ev |= 8; end
          5: begin v = cl(d, m_lim[2]);
               if (v < m_period) m_lvl = v; else ev |= 8; end
          6, 7, 8: m_lim[int'(addr) - 6] = d;
          default: ;
        endcase
      end
      m_stat = (rd ? 0 : m_stat) | ev;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc_n++;
      check(cur_req, {count, stat, irq, rreq},
            {m_cnt[11:0], m_stat[3:0], (m_stat & m_mask & 7) != 0, m_rreq});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); we = 1; addr = a[3:0]; data = d[11:0];
    @(negedge clk); we = 0;
  endtask

  task automatic rs();
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
  endtask

  task automatic rdc();
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    check("R1", {count, stat, irq, rreq}, {12'hFFF, 4'h0, 1'b0, 1'b0});
    cur_req = "R2"; idle(300);
    wr(3, 5); idle(40);
    cur_req = "R13"; wr(3, 7); wr(1, 7); wr(0, 6); wr(5, 8); wr(4, 5);
    cur_req = "R10"; wr(2, 20);  // below nothing: valid
    cur_req = "R3"; rs(); idle(5);
    cur_req = "R4"; idle(60);
    cur_req = "R6"; idle(30);
    cur_req = "R7"; rdc(); idle(3); wr(1, 4); idle(25); wr(1, 1); idle(25);
    wr(1, 7);
    cur_req = "R8";
    for (int i = 0; i < 12; i++) begin idle(i); rdc(); end
    cur_req = "R5";
    rs(); idle(1); rs(); idle(2); rs(); idle(10); rs(); rdc();
    cur_req = "R12";
    for (int i = 0; i < 22; i++) begin rs(); idle(i); end
    cur_req = "R10";
    wr(4, 30); wr(2, 3); wr(5, 20); wr(2, 8); rdc(); wr(2, 25); idle(5);
    cur_req = "R11";
    wr(6, 15); wr(2, 4000); rs(); idle(20); wr(7, 3); wr(4, 10);
    wr(8, 2); wr(5, 11); rs(); idle(30); wr(6, 4095);
    cur_req = "R9";
    wr(0, 7); for (int i = 0; i < 5; i++) begin rs(); idle(3); end
    idle(40); rdc(); wr(0, 6); idle(30);
    cur_req = "R6"; wr(5, 0); rs(); idle(40);
    cur_req = "R2"; wr(3, 6); idle(60); wr(3, 4); idle(200); wr(3, 7);
    cur_req = "R12";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      restart = ($urandom % 9) == 0;
      rd = ($urandom % 7) == 0;
      we = ($urandom % 23) == 0;
      addr = 4'($urandom % 9);
      if (addr == 4'd0) data = 12'($urandom % 8 & 6);
      else if (addr == 4'd3) data = 12'(5 + $urandom % 3);
      else data = 12'($urandom % 40);
    end
    @(negedge clk); restart = 0; rd = 0; we = 0;
    idle(5);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2: watchdog expired, actual %0d cycles expected fewer", cyc_n);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule